// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block is the combinational first stage of a memory management unit. For each access it takes a 32-bit virtual address, an access kind and the current privilege mode. It then picks one of three paths. The first is a bypass, used when translation is switched off. The second is a fixed segment mapping, in which the top address nibble is replaced by a base nibble held in one of two kernel-base words. The third is a page lookup, which is handed to a separate TLB stage.

On the page path the block raises a request strobe. It forwards the virtual page number, the target TLB (instruction or data), a write flag and the user flag. It then builds the physical address from the page frame number and the permission mask that the lookup stage returns. Fault handling and the lookup itself live outside this block.

Top module: `seg_xlat_front`

## Requirements
- R1: When bits 3 and 2 of `glb_cfg` are both 0, `pa` equals `va`, `perm` is 3'b111, and `pg_req`, `pg_itlb`, `pg_write`, `pg_user` and `pg_vpn` are all 0. Every other bit of `glb_cfg` has no effect.
- R2: Translation is on when bit 2 or bit 3 of `glb_cfg` is 1, or both are.
- R3: With translation on, the segment number is `va[31:28]`. The segment is direct-mapped when `mmu_cfg[segment]` is 1.
- R4: The base nibble of a direct-mapped segment s comes from `kbase_lo` when s is 0 to 7, and from `kbase_hi` when s is 8 to 15. In both cases it is the 4-bit field at bit position 4*(s mod 8).
- R5: A direct-mapped access gives `pa = {nibble, va[27:0]}` and `perm = 3'b111`, with `pg_req` and all the other page-side outputs at 0.
- R6: A translated access to a segment that is not direct-mapped raises `pg_req`, sets `pg_vpn = va[31:13]`, `pa = {pg_pfn, 13'b0}` and `perm = pg_perm`.
- R7: The access kind `acc` is encoded as 0 = read, 1 = write, 2 = execute and 3 = read. While `pg_req` is 1, `pg_itlb` is 1 only for execute, and `pg_write` is 1 only for write.
- R8: While `pg_req` is 1, `pg_user` equals `user_mode`. The permission mask bits are [2] read, [1] write and [0] execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| va | input | 32 | Virtual address |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| user_mode | input | 1 | 1 for an access from user mode |
| glb_cfg | input | 32 | Global configuration word; bits 3:2 enable translation |
| mmu_cfg | input | 32 | MMU configuration word; bit s marks segment s as direct-mapped |
| kbase_lo | input | 32 | Base nibbles for segments 0 to 7 |
| kbase_hi | input | 32 | Base nibbles for segments 8 to 15 |
| pg_pfn | input | 19 | Page frame number returned by the page lookup |
| pg_perm | input | 3 | Permission mask returned by the page lookup |
| pa | output | 32 | Physical address |
| perm | output | 3 | Permission mask: [2] read, [1] write, [0] execute |
| pg_req | output | 1 | A page lookup is needed |
| pg_vpn | output | 19 | Virtual page number sent to the lookup |
| pg_itlb | output | 1 | 1 selects the instruction TLB, 0 the data TLB |
| pg_write | output | 1 | The lookup is for a write |
| pg_user | output | 1 | The lookup is for a user-mode access |

## Verification
The bench sets each enable bit on its own and checks that both turn translation on. A design that tests only one of the two bits would bypass accesses that should be translated. It also sets the other `glb_cfg` bits, which a loose decode might mistake for an enable.

Segments 7 and 8 sit at the boundary between the two kernel-base words, and segments 0 and 15 sit at the field extremes. A wrong half-select or a wrong nibble shift shows up there as the wrong top nibble in `pa`. The bench also sends access kind 3, which a decoder that only inspects bit 1 would send to the instruction TLB. It gives the two paths differing `mmu_cfg` patterns under the same address, so that a wrong segment index would pick the wrong path.

// File: rtl/seg_xlat_front.sv
module seg_xlat_front #(
  parameter int VA_W     = 32,
  parameter int SEG_W    = 4,
  parameter int NIB_W    = 4,
  parameter int PG_SHIFT = 13,
  parameter int CFG_W    = 32
) (
  input  logic [VA_W-1:0]                  va,
  input  logic [1:0]                       acc,
  input  logic                             user_mode,
  input  logic [CFG_W-1:0]                 glb_cfg,
  input  logic [CFG_W-1:0]                 mmu_cfg,
  input  logic [((1<<SEG_W)/2)*NIB_W-1:0]  kbase_lo,
  input  logic [((1<<SEG_W)/2)*NIB_W-1:0]  kbase_hi,
  input  logic [VA_W-PG_SHIFT-1:0]         pg_pfn,
  input  logic [2:0]                       pg_perm,
  output logic [VA_W-1:0]                  pa,
  output logic [2:0]                       perm,
  output logic                             pg_req,
  output logic [VA_W-PG_SHIFT-1:0]         pg_vpn,
  output logic                             pg_itlb,
  output logic                             pg_write,
  output logic                             pg_user
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int HALF  = NSEG / 2;
  localparam int KB_W  = HALF * NIB_W;
  localparam int OFF_W = VA_W - SEG_W;
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam logic [2:0] PERM_ALL = 3'b111;

  logic              xlat_on;
  logic [SEG_W-1:0]  seg;
  logic              direct;
  logic [KB_W-1:0]   kb_word;
  logic [NIB_W-1:0]  base_nib;
  logic [VA_W-1:0]   pa_direct;
  logic [VA_W-1:0]   pa_paged;

  logic unused_cfg;
  assign unused_cfg = ^{glb_cfg[CFG_W-1:4], glb_cfg[1:0], mmu_cfg[CFG_W-1:NSEG]};

  assign xlat_on  = glb_cfg[3] | glb_cfg[2];
  assign seg      = va[VA_W-1 -: SEG_W];
  assign direct   = mmu_cfg[seg];
  assign kb_word  = seg[SEG_W-1] ? kbase_hi : kbase_lo;
  assign base_nib = kb_word[seg[SEG_W-2:0]*NIB_W +: NIB_W];

  assign pa_direct = {base_nib, va[OFF_W-1:0]};
  assign pa_paged  = {pg_pfn, {PG_SHIFT{1'b0}}};

  always_comb begin
    pa   = va;
    perm = PERM_ALL;
    if (xlat_on && direct) begin
      pa = pa_direct;
    end else if (xlat_on) begin
      pa   = pa_paged;
      perm = pg_perm;
    end
  end

  assign pg_req   = xlat_on & ~direct;
  assign pg_vpn   = pg_req ? va[VA_W-1:PG_SHIFT] : {VPN_W{1'b0}};
  assign pg_itlb  = pg_req & (acc == 2'd2);
  assign pg_write = pg_req & (acc == 2'd1);
  assign pg_user  = pg_req & user_mode;

  always_comb begin
    if (!$isunknown({va, acc, user_mode, glb_cfg, mmu_cfg, kbase_lo, kbase_hi, pg_pfn, pg_perm})) begin
      // R1
      bypass_ident_chk: assert (xlat_on || (pa == va && perm == PERM_ALL && !pg_req));
      // R5
      direct_offset_chk: assert (!(xlat_on && direct) || (pa[OFF_W-1:0] == va[OFF_W-1:0] && !pg_req));
      // R6
      paged_align_chk: assert (!pg_req || (pa[PG_SHIFT-1:0] == '0 && perm == pg_perm));
      // R7
      tlb_route_chk: assert (!(pg_itlb && pg_write));
      // R8
      user_fwd_chk: assert (pg_req || !pg_user);
    end
  end
endmodule

// File: tb/tb_seg_xlat_front.sv
module tb_seg_xlat_front;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] va, glb_cfg, mmu_cfg, kbase_lo, kbase_hi, pa;
  logic [1:0]  acc;
  logic        user_mode, pg_req, pg_itlb, pg_write, pg_user;
  logic [18:0] pg_pfn, pg_vpn;
  logic [2:0]  pg_perm, perm;

  seg_xlat_front dut (
    .va(va), .acc(acc), .user_mode(user_mode), .glb_cfg(glb_cfg), .mmu_cfg(mmu_cfg),
    .kbase_lo(kbase_lo), .kbase_hi(kbase_hi), .pg_pfn(pg_pfn), .pg_perm(pg_perm),
    .pa(pa), .perm(perm), .pg_req(pg_req), .pg_vpn(pg_vpn), .pg_itlb(pg_itlb),
    .pg_write(pg_write), .pg_user(pg_user)
  );

  typedef struct packed {
    logic [31:0] pa;
    logic [2:0]  perm;
    logic        req;
    logic [18:0] vpn;
    logic        itlb;
    logic        wr;
    logic        usr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  task automatic apply(input logic [31:0] a, input logic [1:0] k, input logic um,
                       input logic [31:0] g, input logic [31:0] m,
                       input logic [31:0] lo, input logic [31:0] hi,
                       input logic [18:0] pfn, input logic [2:0] pp, input string note);
    exp_t e;
    logic [3:0]  s;
    logic [31:0] kb;
    logic [3:0]  nib;
    string t;
    @(negedge clk);
    va = a; acc = k; user_mode = um; glb_cfg = g; mmu_cfg = m;
    kbase_lo = lo; kbase_hi = hi; pg_pfn = pfn; pg_perm = pp;
    e = '0;
    s = a[31:28];
    if (!(g[2] || g[3])) begin
      e.pa = a; e.perm = 3'b111; t = "R1";
    end else if (m[s]) begin
      kb  = (s < 4'd8) ? lo : hi;
      nib = 4'((kb >> (4 * (s % 8))) & 32'hF);
      e.pa = {nib, a[27:0]}; e.perm = 3'b111; t = "R5";
    end else begin
      e.req = 1'b1; e.pa = {pfn, 13'b0}; e.perm = pp; e.vpn = a[31:13];
      e.itlb = (k == 2'd2); e.wr = (k == 2'd1); e.usr = um; t = "R6";
    end
    exp_q.push_back(e);
    tag_q.push_back({t, " ", note});
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e, got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = '{pa, perm, pg_req, pg_vpn, pg_itlb, pg_write, pg_user};
      n_vec++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: actual pa=%h perm=%b req=%b vpn=%h itlb=%b wr=%b usr=%b expected pa=%h perm=%b req=%b vpn=%h itlb=%b wr=%b usr=%b",
                 t, got.pa, got.perm, got.req, got.vpn, got.itlb, got.wr, got.usr,
                 e.pa, e.perm, e.req, e.vpn, e.itlb, e.wr, e.usr);
      end
    end
  end

  localparam logic [31:0] KLO = 32'h7654_3210 ^ 32'h8888_8888;
  localparam logic [31:0] KHI = 32'h1F2E_3D4C;

  initial begin
    // reset-like all-zero state: R1 bypass
    apply(32'h0, 2'd0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 19'h0, 3'b000, "zero");
    // R1: other cfg bits set, still bypass
    apply(32'hDEAD_BEEF, 2'd2, 1'b1, 32'hFFFF_FFF3, 32'hFFFF, KLO, KHI, 19'h1234, 3'b001, "other bits");
    // R2: each enable bit alone, paged
    apply(32'h1234_5678, 2'd0, 1'b0, 32'h4, 32'h0, KLO, KHI, 19'h4_5A5A, 3'b100, "R2 bit2");
    apply(32'h1234_5678, 2'd1, 1'b1, 32'h8, 32'h0, KLO, KHI, 19'h7_0001, 3'b110, "R2 bit3");
    apply(32'h1234_5678, 2'd2, 1'b0, 32'hC, 32'h0, KLO, KHI, 19'h0_0F0F, 3'b101, "R2 both R7 exec");
    // R7: kind 3 as read
    apply(32'hA000_2000, 2'd3, 1'b1, 32'h4, 32'h0, KLO, KHI, 19'h3_3333, 3'b111, "R7 kind3 R8");
    // R4 segment boundaries
    apply(32'h0ABC_DEF0, 2'd0, 1'b0, 32'h4, 32'h0001, KLO, KHI, 19'h0, 3'b0, "R4 seg0");
    apply(32'h7123_4567, 2'd1, 1'b0, 32'h4, 32'h0080, KLO, KHI, 19'h0, 3'b0, "R4 seg7");
    apply(32'h8765_4321, 2'd2, 1'b1, 32'h8, 32'h0100, KLO, KHI, 19'h0, 3'b0, "R4 seg8");
    apply(32'hFFFF_FFFF, 2'd0, 1'b0, 32'h8, 32'h8000, KLO, KHI, 19'h0, 3'b0, "R4 seg15");
    // R3: same address, only neighbouring segment direct -> paged
    apply(32'h5000_1FFF, 2'd1, 1'b1, 32'h4, 32'hFFDF, KLO, KHI, 19'h5_5555, 3'b010, "R3 neighbour");
    apply(32'h5000_1FFF, 2'd1, 1'b1, 32'h4, 32'h0020, KLO, KHI, 19'h5_5555, 3'b010, "R3 own bit");
    for (int i = 0; i < 300; i++) begin
      apply($urandom, 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom, $urandom,
            19'($urandom), 3'($urandom), "random");
    end
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule